// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block gathers interrupt requests from a parameterised set of sources and one non-maskable input. Each source has a pending flag and a programmable priority. The controller picks the most urgent eligible request and compares it with the running level. The running level is the most urgent of three things: the priority of the innermost active handler, the level set by the two all-blocking masks, and the level set by the threshold mask. When the candidate is strictly more urgent, the controller raises a preemption request that carries the exception number. The core uses that number directly as an index into its handler address table.

When the core accepts a request, the block pushes that request onto an internal nesting stack and marks the source active. An active source cannot be taken again until its handler returns. It can still pend again, and its priority can be rewritten. A return strobe pops the stack and restores the level of the interrupted handler, or the thread level once the stack is empty. Software programs priorities and masks through a single-cycle write port.

Top module: `nest_irq_ctrl`

## Requirements
- R1: After reset nothing is pending, `preempt_req` is low, `act_depth` is 0 and `act_num` is 0 (thread). Every priority and mask register reads as zero.
- R2: A source pend bit is set on a rising edge of its input and stays set until that source is accepted. A level held high after acceptance does not set the bit again.
- R3: The exception number of source i is 16+i and the non-maskable input has number 2. A lower priority value is more urgent. On equal priority the lower number wins. The non-maskable input beats every source. `preempt_num` is 0 whenever `preempt_req` is low.
- R4: A request is raised only if its priority is strictly more urgent than that of the innermost active handler. Equal priority does not preempt.
- R5: When `ack` is high while `preempt_req` is high, the block pushes the request: `act_depth` rises by one, `act_num` takes the number, and the pend bit clears. `exc_ret` pops one level, restoring the previous `act_num`, or 0 when the stack empties. `exc_ret` on an empty stack is ignored. When `exc_ret` and `ack` arrive in the same cycle, only the return takes place.
- R6: An active source is never offered again while active, even if it pends again and its priority is rewritten to the most urgent value. Its pend bit does set again on a new edge.
- R7: Writing 1 to bit 0 at address 0xF0 (global mask) blocks every source. The non-maskable input still preempts.
- R8: Writing 1 to bit 0 at address 0xF1 (fault mask) likewise blocks every source but not the non-maskable input.
- R9: A nonzero value b written to address 0xF2 (threshold) blocks sources whose priority value is b or larger. The value 0 disables threshold masking.
- R10: A write to address i (i < NUM_SRC) sets the priority of source i from the low PRIO_W data bits. The change takes effect from the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | NUM_SRC | Source request lines, edge captured |
| nmi_in | input | 1 | Non-maskable request, edge captured |
| ack | input | 1 | Core accepts the presented request |
| exc_ret | input | 1 | Handler return strobe |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 8 | Register address |
| wr_data | input | 8 | Register write data |
| preempt_req | output | 1 | Preemption request to the core |
| preempt_num | output | $clog2(NUM_SRC+16) | Exception number of the request |
| act_num | output | $clog2(NUM_SRC+16) | Number of innermost active handler, 0 in thread |
| act_depth | output | $clog2(2**PRIO_W+2) | Current nesting depth |
| pend_vec | output | NUM_SRC | Pend bits of the sources |

## Verification
A corrupted stack entry stays hidden until its level is popped. At that point it shows up as a wrong `act_num`, or as a `preempt_req` that is raised or withheld against the restored level, within the cycle after the return strobe. A stuck active flag appears as a pending source that is never offered after its handler returns. A wrong mask or priority register changes `preempt_req` or `preempt_num` in the cycle after the write. The bench model therefore compares every output on every cycle, so any such fault is reported no later than the next nesting event that touches it.

// File: rtl/nic_pkg.sv
package nic_pkg;
   localparam int NMI_EXC      = 2;
   localparam int IRQ_EXC_BASE = 16;
   localparam int MAX_SRC      = 240;
   localparam int MAX_PRIO_W   = 8;
   localparam int REG_AW       = 8;
   localparam int REG_DW       = 8;
   localparam logic [REG_AW-1:0] ADDR_GMASK = 8'hF0;
   localparam logic [REG_AW-1:0] ADDR_FMASK = 8'hF1;
   localparam logic [REG_AW-1:0] ADDR_THR   = 8'hF2;
endpackage

// File: rtl/nic_pend.sv
module nic_pend
   import nic_pkg::*;
#(
   parameter int NUM_SRC = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] irq_in,
   input  logic               nmi_in,
   input  logic [NUM_SRC-1:0] clr_src,
   input  logic               clr_nmi,
   output logic [NUM_SRC-1:0] pend_src,
   output logic               pend_nmi
);
   logic [NUM_SRC-1:0] irq_q;
   logic               nmi_q;

   // per-source edge capture; a new edge wins over a same-cycle clear
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            irq_q[i]    <= 1'b0;
            pend_src[i] <= 1'b0;
         end else begin
            irq_q[i]    <= irq_in[i];
            pend_src[i] <= (pend_src[i] & ~clr_src[i]) | (irq_in[i] & ~irq_q[i]);
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         nmi_q    <= 1'b0;
         pend_nmi <= 1'b0;
      end else begin
         nmi_q    <= nmi_in;
         pend_nmi <= (pend_nmi & ~clr_nmi) | (nmi_in & ~nmi_q);
      end
   end
endmodule

// File: rtl/nic_pick.sv
module nic_pick
   import nic_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int PRIO_W  = 3,
   parameter int EXC_W   = 6
) (
   input  logic [NUM_SRC-1:0]        pend_src,
   input  logic                      pend_nmi,
   input  logic [NUM_SRC-1:0]        act_src,
   input  logic                      act_nmi,
   input  logic [NUM_SRC*PRIO_W-1:0] prio_flat,
   output logic                      cand_vld,
   output logic [EXC_W-1:0]          cand_num,
   output logic [PRIO_W:0]           cand_ep
);
   localparam int EP_W = PRIO_W + 1;

   logic [NUM_SRC-1:0] elig;
   logic [EP_W-1:0]    src_ep [NUM_SRC];

   // extended priority: 0 is the non-maskable level, sources sit at prio+1
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_ep
      assign elig[i]   = pend_src[i] & ~act_src[i];
      assign src_ep[i] = {1'b0, prio_flat[i*PRIO_W +: PRIO_W]} + EP_W'(1);
   end

   always_comb begin
      cand_vld = 1'b0;
      cand_num = '0;
      cand_ep  = '1;
      // strict compare keeps the lowest index on equal priority
      for (int i = 0; i < NUM_SRC; i++) begin
         if (elig[i] && (src_ep[i] < cand_ep)) begin
            cand_vld = 1'b1;
            cand_num = EXC_W'(IRQ_EXC_BASE + i);
            cand_ep  = src_ep[i];
         end
      end
      if (pend_nmi && !act_nmi) begin
         cand_vld = 1'b1;
         cand_num = EXC_W'(NMI_EXC);
         cand_ep  = '0;
      end
   end
endmodule

// File: rtl/nic_stack.sv
module nic_stack
   import nic_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int PRIO_W  = 3,
   parameter int EXC_W   = 6,
   parameter int DEPTH   = 9
) (
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           push,
   input  logic [EXC_W-1:0]               push_num,
   input  logic [PRIO_W:0]                push_ep,
   input  logic                           pop,
   output logic [EXC_W-1:0]               top_num,
   output logic [PRIO_W:0]                top_ep,
   output logic [$clog2(DEPTH+1)-1:0]     depth,
   output logic [NUM_SRC-1:0]             act_src,
   output logic                           act_nmi
);
   localparam int EP_W      = PRIO_W + 1;
   localparam int DCNT_W    = $clog2(DEPTH + 1);
   localparam int IDX_W     = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int THREAD_EP = (1 << PRIO_W) + 1;

   logic [EXC_W-1:0] num_mem [DEPTH];
   logic [EP_W-1:0]  ep_mem  [DEPTH];
   logic             push_ok, pop_ok;

   assign pop_ok  = pop && (depth != '0);
   assign push_ok = push && !pop && (depth < DCNT_W'(DEPTH));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       depth <= '0;
      else if (pop_ok)  depth <= depth - DCNT_W'(1);
      else if (push_ok) depth <= depth + DCNT_W'(1);
   end

   always_ff @(posedge clk) begin
      if (push_ok) begin
         num_mem[IDX_W'(depth)] <= push_num;
         ep_mem[IDX_W'(depth)]  <= push_ep;
      end
   end

   always_comb begin
      if (depth == '0) begin
         top_num = '0;
         top_ep  = EP_W'(THREAD_EP);
      end else begin
         top_num = num_mem[IDX_W'(depth - DCNT_W'(1))];
         top_ep  = ep_mem[IDX_W'(depth - DCNT_W'(1))];
      end
   end

   // active flags follow pushes and pops of their own exception number
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_act
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            act_src[i] <= 1'b0;
         else if (push_ok && push_num == EXC_W'(IRQ_EXC_BASE + i))
            act_src[i] <= 1'b1;
         else if (pop_ok && top_num == EXC_W'(IRQ_EXC_BASE + i))
            act_src[i] <= 1'b0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         act_nmi <= 1'b0;
      else if (push_ok && push_num == EXC_W'(NMI_EXC))
         act_nmi <= 1'b1;
      else if (pop_ok && top_num == EXC_W'(NMI_EXC))
         act_nmi <= 1'b0;
   end
endmodule

// File: rtl/nest_irq_ctrl.sv
module nest_irq_ctrl
   import nic_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int PRIO_W  = 3
) (
   input  logic                                   clk,
   input  logic                                   rst_n,
   input  logic [NUM_SRC-1:0]                     irq_in,
   input  logic                                   nmi_in,
   input  logic                                   ack,
   input  logic                                   exc_ret,
   input  logic                                   wr_en,
   input  logic [7:0]                             wr_addr,
   input  logic [7:0]                             wr_data,
   output logic                                   preempt_req,
   output logic [$clog2(NUM_SRC+16)-1:0]          preempt_num,
   output logic [$clog2(NUM_SRC+16)-1:0]          act_num,
   output logic [$clog2((1<<PRIO_W)+2)-1:0]       act_depth,
   output logic [NUM_SRC-1:0]                     pend_vec
);
   localparam int EXC_W  = $clog2(NUM_SRC + IRQ_EXC_BASE);
   localparam int EP_W   = PRIO_W + 1;
   localparam int DEPTH  = (1 << PRIO_W) + 1;
   localparam int DCNT_W = $clog2(DEPTH + 1);

   if (NUM_SRC < 1 || NUM_SRC > MAX_SRC) begin : g_bad_src
      $error("NUM_SRC must lie in 1..240");
   end
   if (PRIO_W < 1 || PRIO_W > MAX_PRIO_W) begin : g_bad_prio
      $error("PRIO_W must lie in 1..8");
   end

   logic [NUM_SRC*PRIO_W-1:0] prio_flat;
   logic                      gmask_q, fmask_q;
   logic [PRIO_W-1:0]         thr_q;
   logic [NUM_SRC-1:0]        pend_src, act_src, clr_src;
   logic                      pend_nmi, act_nmi, clr_nmi;
   logic                      cand_vld;
   logic [EXC_W-1:0]          cand_num, top_num;
   logic [EP_W-1:0]           cand_ep, top_ep, run_ep;
   logic                      accept;

   // priority registers, one per source
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_prio
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            prio_flat[i*PRIO_W +: PRIO_W] <= '0;
         else if (wr_en && wr_addr == REG_AW'(i))
            prio_flat[i*PRIO_W +: PRIO_W] <= wr_data[PRIO_W-1:0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gmask_q <= 1'b0;
         fmask_q <= 1'b0;
         thr_q   <= '0;
      end else if (wr_en) begin
         if (wr_addr == ADDR_GMASK) gmask_q <= wr_data[0];
         if (wr_addr == ADDR_FMASK) fmask_q <= wr_data[0];
         if (wr_addr == ADDR_THR)   thr_q   <= wr_data[PRIO_W-1:0];
      end
   end

   nic_pend #(.NUM_SRC(NUM_SRC)) u_pend (
      .clk      (clk),
      .rst_n    (rst_n),
      .irq_in   (irq_in),
      .nmi_in   (nmi_in),
      .clr_src  (clr_src),
      .clr_nmi  (clr_nmi),
      .pend_src (pend_src),
      .pend_nmi (pend_nmi)
   );

   nic_pick #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .EXC_W(EXC_W)) u_pick (
      .pend_src  (pend_src),
      .pend_nmi  (pend_nmi),
      .act_src   (act_src),
      .act_nmi   (act_nmi),
      .prio_flat (prio_flat),
      .cand_vld  (cand_vld),
      .cand_num  (cand_num),
      .cand_ep   (cand_ep)
   );

   nic_stack #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W), .EXC_W(EXC_W), .DEPTH(DEPTH)) u_stack (
      .clk      (clk),
      .rst_n    (rst_n),
      .push     (accept),
      .push_num (cand_num),
      .push_ep  (cand_ep),
      .pop      (exc_ret),
      .top_num  (top_num),
      .top_ep   (top_ep),
      .depth    (act_depth),
      .act_src  (act_src),
      .act_nmi  (act_nmi)
   );

   // running level: innermost handler, lowered by threshold and full masks
   always_comb begin
      run_ep = top_ep;
      if (thr_q != '0 && ({1'b0, thr_q} + EP_W'(1)) < run_ep)
         run_ep = {1'b0, thr_q} + EP_W'(1);
      if ((gmask_q || fmask_q) && run_ep > EP_W'(1))
         run_ep = EP_W'(1);
   end

   assign preempt_req = cand_vld && (cand_ep < run_ep);
   assign preempt_num = preempt_req ? cand_num : '0;
   assign accept      = ack && preempt_req && !exc_ret;
   assign clr_nmi     = accept && (cand_num == EXC_W'(NMI_EXC));

   for (genvar i = 0; i < NUM_SRC; i++) begin : g_clr
      assign clr_src[i] = accept && (cand_num == EXC_W'(IRQ_EXC_BASE + i));
   end

   assign act_num  = top_num;
   assign pend_vec = pend_src;
endmodule

// File: rtl/nic_chk.sv
module nic_chk
   import nic_pkg::*;
#(
   parameter int NUM_SRC = 32,
   parameter int PRIO_W  = 3
) (
   input logic                                clk,
   input logic                                rst_n,
   input logic                                ack,
   input logic                                exc_ret,
   input logic                                preempt_req,
   input logic [$clog2(NUM_SRC+16)-1:0]       preempt_num,
   input logic [$clog2(NUM_SRC+16)-1:0]       act_num,
   input logic [$clog2((1<<PRIO_W)+2)-1:0]    act_depth,
   input logic [NUM_SRC-1:0]                  pend_vec,
   input logic [NUM_SRC-1:0]                  act_src,
   input logic                                gmask_q,
   input logic                                fmask_q,
   input logic [PRIO_W:0]                     cand_ep,
   input logic [PRIO_W:0]                     top_ep
);
   localparam int EXC_W = $clog2(NUM_SRC + IRQ_EXC_BASE);

   logic [NUM_SRC-1:0] req_vec, acc_vec;
   for (genvar i = 0; i < NUM_SRC; i++) begin : g_vec
      assign req_vec[i] = preempt_req && (preempt_num == EXC_W'(IRQ_EXC_BASE + i));
      assign acc_vec[i] = req_vec[i] && ack && !exc_ret;
   end

   assert_pend_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((($past(pend_vec) & ~$past(acc_vec)) & ~pend_vec) == '0));

   assert_beats_running_R4: assert property (@(posedge clk) disable iff (!rst_n)
      preempt_req |-> (cand_ep < top_ep));

   assert_push_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (preempt_req && ack && !exc_ret) |=>
         (act_depth == $past(act_depth) + 1'b1) && (act_num == $past(preempt_num)));

   assert_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_ret && act_depth != '0) |=> (act_depth == $past(act_depth) - 1'b1));

   assert_empty_ret_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (exc_ret && act_depth == '0) |=> (act_depth == '0) && (act_num == '0));

   assert_no_reentry_R6: assert property (@(posedge clk) disable iff (!rst_n)
      preempt_req |-> ((req_vec & act_src) == '0));

   // covers R7 and R8: either full mask leaves only the non-maskable input
   assert_mask_nmi_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
      ((gmask_q || fmask_q) && preempt_req) |-> (preempt_num == EXC_W'(NMI_EXC)));
endmodule

bind nest_irq_ctrl nic_chk #(.NUM_SRC(NUM_SRC), .PRIO_W(PRIO_W)) u_nic_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ack         (ack),
   .exc_ret     (exc_ret),
   .preempt_req (preempt_req),
   .preempt_num (preempt_num),
   .act_num     (act_num),
   .act_depth   (act_depth),
   .pend_vec    (pend_vec),
   .act_src     (act_src),
   .gmask_q     (gmask_q),
   .fmask_q     (fmask_q),
   .cand_ep     (cand_ep),
   .top_ep      (top_ep)
);

// File: tb/nest_irq_ctrl_test.sv
module nest_irq_ctrl_test;
   localparam int NS = 32;
   localparam int PW = 3;
   localparam int EW = 6;
   localparam int DW = 4;
   localparam int THREAD = (1 << PW) + 1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NS-1:0] irq_in = '0;
   logic          nmi_in = 1'b0, ack = 1'b0, exc_ret = 1'b0, wr_en = 1'b0;
   logic [7:0]    wr_addr = '0, wr_data = '0;
   logic          preempt_req;
   logic [EW-1:0] preempt_num, act_num;
   logic [DW-1:0] act_depth;
   logic [NS-1:0] pend_vec;

   int n_vec = 0, n_bad = 0;

   always #5 clk = ~clk;

   nest_irq_ctrl #(.NUM_SRC(NS), .PRIO_W(PW)) uut (
      .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .nmi_in(nmi_in), .ack(ack),
      .exc_ret(exc_ret), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .preempt_req(preempt_req), .preempt_num(preempt_num), .act_num(act_num),
      .act_depth(act_depth), .pend_vec(pend_vec)
   );

   // ---------------- behavioural reference model ----------------
   int         m_prio [NS];
   bit [NS-1:0] m_pend, m_act, m_prev;
   bit         m_npend, m_nact, m_nprev, m_g, m_f;
   int         m_thr;
   int         stk_num[$];
   int         stk_ep[$];

   function automatic void m_eval(output bit req, output int num);
      int best = 1000;
      int bn = 0;
      int run, lim;
      for (int i = 0; i < NS; i++)
         if (m_pend[i] && !m_act[i] && (m_prio[i] + 1) < best) begin
            best = m_prio[i] + 1;
            bn = 16 + i;
         end
      if (m_npend && !m_nact) begin
         best = 0;
         bn = 2;
      end
      run = (stk_ep.size() == 0) ? THREAD : stk_ep[stk_ep.size()-1];
      lim = THREAD;
      if (m_thr != 0) lim = m_thr + 1;
      if (m_g || m_f) lim = 1;
      if (lim < run) run = lim;
      req = (bn != 0) && (best < run);
      num = req ? bn : 0;
   endfunction

   always @(posedge clk) begin : model
      bit r;
      int n, t;
      if (!rst_n) begin
         for (int i = 0; i < NS; i++) m_prio[i] = 0;
         m_pend = '0; m_act = '0; m_prev = '0;
         m_npend = 0; m_nact = 0; m_nprev = 0; m_g = 0; m_f = 0; m_thr = 0;
         stk_num.delete();
         stk_ep.delete();
      end else begin
         m_eval(r, n);
         if (exc_ret) begin
            if (stk_num.size() != 0) begin
               t = stk_num.pop_back();
               void'(stk_ep.pop_back());
               if (t == 2) m_nact = 0; else m_act[t-16] = 0;
            end
         end else if (ack && r) begin
            stk_num.push_back(n);
            if (n == 2) begin
               stk_ep.push_back(0);
               m_npend = 0; m_nact = 1;
            end else begin
               stk_ep.push_back(m_prio[n-16] + 1);
               m_pend[n-16] = 0; m_act[n-16] = 1;
            end
         end
         m_pend  = m_pend | (irq_in & ~m_prev);
         m_npend = m_npend | (nmi_in & ~m_nprev);
         m_prev  = irq_in;
         m_nprev = nmi_in;
         if (wr_en) begin
            if (wr_addr < NS) m_prio[wr_addr] = int'(wr_data[PW-1:0]);
            else if (wr_addr == 8'hF0) m_g = wr_data[0];
            else if (wr_addr == 8'hF1) m_f = wr_data[0];
            else if (wr_addr == 8'hF2) m_thr = int'(wr_data[PW-1:0]);
         end
      end
   end

   task automatic chk(string tag, string what, longint act, longint exp);
      n_vec++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin : compare
      bit r;
      int n;
      if (rst_n) begin
         m_eval(r, n);
         chk("R3", "preempt_req", preempt_req, r);
         chk("R3", "preempt_num", preempt_num, n);
         chk("R5", "act_num", act_num, (stk_num.size() == 0) ? 0 : stk_num[stk_num.size()-1]);
         chk("R5", "act_depth", act_depth, stk_num.size());
         chk("R2", "pend_vec", pend_vec, m_pend);
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic wr(input int a, input int d);
      wr_en = 1'b1; wr_addr = 8'(a); wr_data = 8'(d);
      tick();
      wr_en = 1'b0;
   endtask

   task automatic pulse(input int s);
      irq_in[s] = 1'b1;
      tick();
      irq_in[s] = 1'b0;
   endtask

   task automatic take();
      ack = 1'b1;
      tick();
      ack = 1'b0;
   endtask

   task automatic leave();
      exc_ret = 1'b1;
      tick();
      exc_ret = 1'b0;
   endtask

   task automatic drain();
      for (int k = 0; k < 60; k++) begin
         if (preempt_req) take();
         else if (act_depth != '0) leave();
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   endtask

   initial begin : watchdog
      #(200000 * 10);
      n_bad++;
      $display("FAIL R1 watchdog: actual hung expected finished");
      finish_run();
   end

   initial begin : main
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state
      chk("R1", "reset preempt_req", preempt_req, 0);
      chk("R1", "reset act_depth", act_depth, 0);
      chk("R1", "reset act_num", act_num, 0);
      chk("R1", "reset pend_vec", pend_vec, 0);
      rst_n = 1'b1;
      tick(); tick();

      // R2/R3: single source, level held over acceptance
      irq_in[5] = 1'b1;
      tick();
      chk("R2", "pend set on edge", pend_vec[5], 1);
      chk("R3", "source 5 number", preempt_num, 21);
      take();
      chk("R2", "pend cleared on accept", pend_vec[5], 0);
      chk("R5", "accepted number", act_num, 21);
      tick();
      chk("R2", "held level no repend", pend_vec[5], 0);
      irq_in[5] = 1'b0;
      leave();
      chk("R5", "back to thread", act_num, 0);

      // R10/R3: priorities and equal-priority tie
      wr(3, 4); wr(7, 2); wr(9, 2);
      irq_in[3] = 1'b1; irq_in[7] = 1'b1; irq_in[9] = 1'b1;
      tick();
      irq_in = '0;
      chk("R3", "tie lowest number", preempt_num, 23);
      chk("R10", "written priority used", preempt_req, 1);
      take();
      chk("R4", "equal priority no preempt", preempt_req, 0);

      // R4/R5: nesting
      wr(12, 1);
      pulse(12);
      chk("R4", "more urgent preempts", preempt_num, 28);
      take();
      chk("R5", "nested depth", act_depth, 2);
      leave();
      chk("R5", "restored previous", act_num, 23);

      // R6: active source blocked despite repend and priority rewrite
      pulse(7);
      chk("R6", "repend while active", pend_vec[7], 1);
      wr(7, 0);
      chk("R6", "active not offered", preempt_req, 0);
      leave();
      chk("R6", "offered after return", preempt_num, 23);
      drain();

      // R5: return on empty stack
      leave();
      chk("R5", "empty return ignored", act_depth, 0);

      // R7: global mask
      wr(8'hF0, 1);
      pulse(4);
      chk("R7", "global mask blocks", preempt_req, 0);
      nmi_in = 1'b1; tick(); nmi_in = 1'b0;
      chk("R7", "nmi passes global mask", preempt_num, 2);
      take(); leave();
      wr(8'hF0, 0);
      chk("R7", "unmasked source offered", preempt_num, 20);

      // R8: fault mask
      wr(8'hF1, 1);
      chk("R8", "fault mask blocks", preempt_req, 0);
      wr(8'hF1, 0);
      chk("R8", "fault mask released", preempt_num, 20);
      drain();

      // R9: threshold
      wr(8'hF2, 3); wr(10, 3); wr(11, 2);
      pulse(10);
      chk("R9", "at threshold blocked", preempt_req, 0);
      pulse(11);
      chk("R9", "below threshold passes", preempt_num, 27);
      take(); leave();
      chk("R9", "still blocked", preempt_req, 0);
      wr(8'hF2, 0);
      chk("R9", "zero disables threshold", preempt_num, 26);
      drain();

      // R5: return and accept in one cycle
      pulse(13);
      ack = 1'b1; exc_ret = 1'b1;
      tick();
      ack = 1'b0; exc_ret = 1'b0;
      chk("R5", "return wins over accept", act_depth, 0);
      chk("R5", "pend kept", pend_vec[13], 1);
      drain();

      // R3: non-maskable beats the most urgent source
      irq_in[14] = 1'b1; nmi_in = 1'b1;
      tick();
      irq_in = '0; nmi_in = 1'b0;
      chk("R3", "nmi wins", preempt_num, 2);
      drain();

      // mixed traffic, checked every cycle by the model
      for (int k = 0; k < 4000; k++) begin
         irq_in  = ($urandom % 4 == 0) ? (NS'(1) << ($urandom % NS)) : '0;
         nmi_in  = ($urandom % 70 == 0);
         ack     = ($urandom % 3 == 0);
         exc_ret = ($urandom % 5 == 0);
         wr_en   = ($urandom % 12 == 0);
         wr_addr = ($urandom % 6 == 0) ? 8'(8'hF0 + ($urandom % 3)) : 8'($urandom % NS);
         wr_data = 8'($urandom);
         tick();
      end
      irq_in = '0; nmi_in = 1'b0; ack = 1'b0; exc_ret = 1'b0; wr_en = 1'b0;
      tick(); tick();
      finish_run();
   end
endmodule